// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit performs a byte permutation through a lookup table built from consecutive 128-bit vector registers. It takes eight 8-bit indices packed into a 64-bit word, along with a 64-bit seed value. The seed is zero for the plain lookup. For the extend form it is the old destination contents. The caller also supplies the number of the first table register and a table length of one to four registers. The unit then gathers one byte per index lane and returns the 64-bit result.

The table bytes sit in an external 32-register vector file. The unit sees that file as 64 half-registers of 64 bits each, reached through a single read port. Lanes are handled one per cycle, starting at lane 0. The unit issues a read only for lanes whose index falls inside the table. Each byte returned by a read is merged into its lane one cycle after the read was issued. A lane whose index points past the end of the table keeps its seed byte. A table that starts near the top of the register file continues from register 0.

Top module: `tlu_table_lookup`

## Requirements
- R1: After reset, `done` and `rd_en` are low and `result` is zero.
- R2: Index byte `i` of a lane is in range exactly when `i < 16 * (tbl_len + 1)`, where `tbl_len` encodes lengths 0..3 as 1..4 registers.
- R3: For an in-range lane, the source half-register address is `(2 * base_reg + i[7:3]) mod 64`. The source byte is byte `i[2:0]` of the returned word, with byte 0 at bits 7:0. The result takes it in lane bits `8*lane+7 : 8*lane`.
- R4: A table that runs past vector register 31 continues at register 0, which is half-register address 0.
- R5: An out-of-range lane outputs the matching byte of `init_vec` unchanged. This gives zero for a plain lookup with a zero seed.
- R6: Exactly one read is issued per in-range lane and none per out-of-range lane. Reads go out in ascending lane order, one per cycle at most.
- R7: `done` is a one-cycle pulse that is high in the tenth cycle after the clock edge that accepts `start`. `result` then holds its value until the next accepted start.
- R8: A `start` seen while an operation is in progress is ignored. The running operation's result and read sequence stay unchanged.
- R9: `rd_data` is taken as the answer to the read issued in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| idx_vec | input | 64 | Eight byte indices, lane 0 in bits 7:0 |
| init_vec | input | 64 | Seed result; out-of-range lanes keep its bytes |
| base_reg | input | 5 | First vector register of the table |
| tbl_len | input | 2 | Table length minus one (0..3 means 1..4 registers) |
| rd_en | output | 1 | Read request to the vector file |
| rd_addr | output | 6 | Half-register address of the read |
| rd_data | input | 64 | Read data, valid one cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Looked-up vector |

## Verification
The hardest case to reach is a table that crosses the top of the register file. Such a table needs a start register near 31, a length above one, and indices that land in the part past the wrap. The sweep reaches it by running starting registers 30 and 31 against every table length. It also covers all 256 index values, spread over 32 index words in a shuffled lane order, so every in-range and out-of-range index is seen at the wrap point. A second case is a start request arriving mid-operation with different operands. That case is driven deliberately: the bench checks the result and the logged read addresses against the first operation only.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
    localparam int unsigned LANES      = 8;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned VEC_W      = LANES * BYTE_W;
    localparam int unsigned LANE_W     = $clog2(LANES);
    localparam int unsigned HADDR_W    = 6;
    localparam int unsigned REG_W      = HADDR_W - 1;
    localparam int unsigned LEN_W      = 2;
    localparam int unsigned BYTES_PER_REG_LG = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } tlu_state_e;
endpackage

// File: rtl/tlu_lane_decode.sv
module tlu_lane_decode #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned HADDR_W = 6,
    parameter int unsigned LEN_W   = 2,
    parameter int unsigned REG_LG  = 4
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [HADDR_W-2:0] base,
    input  logic [LEN_W-1:0]   len_m1,
    output logic               hit,
    output logic [HADDR_W-1:0] half_addr,
    output logic [2:0]         byte_sel
);
    localparam int unsigned LIM_W = IDX_W + 2;

    logic [LIM_W-1:0] limit;
    logic [HADDR_W-1:0] base_half;
    logic [HADDR_W-1:0] word_off;

    always_comb begin
        limit     = LIM_W'((32'(len_m1) + 32'd1) << REG_LG);
        hit       = LIM_W'(idx) < limit;
        base_half = {base, 1'b0};
        word_off  = HADDR_W'(idx >> 3);
        half_addr = base_half + word_off;
        byte_sel  = idx[2:0];
    end
endmodule

// File: rtl/tlu_byte_pick.sv
module tlu_byte_pick #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NBYTES = 8,
    parameter int unsigned SEL_W  = $clog2(NBYTES)
) (
    input  logic [BYTE_W*NBYTES-1:0] word,
    input  logic [SEL_W-1:0]         sel,
    output logic [BYTE_W-1:0]        byte_o
);
    logic [BYTE_W-1:0] bytes_w [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_split
        assign bytes_w[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = bytes_w[sel];
endmodule

// File: rtl/tlu_byte_insert.sv
module tlu_byte_insert #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NBYTES = 8,
    parameter int unsigned SEL_W  = $clog2(NBYTES)
) (
    input  logic [BYTE_W*NBYTES-1:0] vec_i,
    input  logic                     en,
    input  logic [SEL_W-1:0]         lane,
    input  logic [BYTE_W-1:0]        val,
    output logic [BYTE_W*NBYTES-1:0] vec_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign vec_o[g*BYTE_W +: BYTE_W] =
            (en && (lane == SEL_W'(g))) ? val : vec_i[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/tlu_table_lookup.sv
module tlu_table_lookup
    import tlu_pkg::*;
#(
    parameter int unsigned N_LANES  = LANES,
    parameter int unsigned B_W      = BYTE_W,
    parameter int unsigned HA_W     = HADDR_W,
    parameter int unsigned TL_W     = LEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_LANES*B_W-1:0]  idx_vec,
    input  logic [N_LANES*B_W-1:0]  init_vec,
    input  logic [HA_W-2:0]         base_reg,
    input  logic [TL_W-1:0]         tbl_len,
    output logic                    rd_en,
    output logic [HA_W-1:0]         rd_addr,
    input  logic [N_LANES*B_W-1:0]  rd_data,
    output logic                    done,
    output logic [N_LANES*B_W-1:0]  result
);
    localparam int unsigned V_W  = N_LANES * B_W;
    localparam int unsigned L_W  = $clog2(N_LANES);
    localparam int unsigned WB   = 8;
    localparam int unsigned WS_W = $clog2(WB);

    typedef struct packed {
        tlu_state_e       st;
        logic [L_W-1:0]   lane;
        logic [V_W-1:0]   idx;
        logic [HA_W-2:0]  base;
        logic [TL_W-1:0]  len;
        logic [V_W-1:0]   res;
        logic             pend_vld;
        logic [L_W-1:0]   pend_lane;
        logic [WS_W-1:0]  pend_sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [B_W-1:0]  cur_idx;
    logic            cur_hit;
    logic [HA_W-1:0] cur_addr;
    logic [2:0]      cur_sel;
    logic [B_W-1:0]  fetched;
    logic [V_W-1:0]  merged;

    assign cur_idx = ctl_q.idx[int'(ctl_q.lane)*B_W +: B_W];

    tlu_lane_decode #(
        .IDX_W  (B_W),
        .HADDR_W(HA_W),
        .LEN_W  (TL_W),
        .REG_LG (BYTES_PER_REG_LG)
    ) u_dec (
        .idx      (cur_idx),
        .base     (ctl_q.base),
        .len_m1   (ctl_q.len),
        .hit      (cur_hit),
        .half_addr(cur_addr),
        .byte_sel (cur_sel)
    );

    tlu_byte_pick #(
        .BYTE_W(B_W),
        .NBYTES(WB)
    ) u_pick (
        .word  (rd_data),
        .sel   (ctl_q.pend_sel),
        .byte_o(fetched)
    );

    tlu_byte_insert #(
        .BYTE_W(B_W),
        .NBYTES(N_LANES)
    ) u_ins (
        .vec_i(ctl_q.res),
        .en   (ctl_q.pend_vld),
        .lane (ctl_q.pend_lane),
        .val  (fetched),
        .vec_o(merged)
    );

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.res = merged;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.pend_vld = 1'b0;
                if (start) begin
                    ctl_d.st   = ST_ISSUE;
                    ctl_d.lane = '0;
                    ctl_d.idx  = idx_vec;
                    ctl_d.base = base_reg;
                    ctl_d.len  = tbl_len;
                    ctl_d.res  = init_vec;
                end
            end
            ST_ISSUE: begin
                ctl_d.pend_vld  = cur_hit;
                ctl_d.pend_lane = ctl_q.lane;
                ctl_d.pend_sel  = WS_W'(cur_sel);
                if (ctl_q.lane == L_W'(N_LANES - 1)) begin
                    ctl_d.st = ST_DRAIN;
                end else begin
                    ctl_d.lane = ctl_q.lane + L_W'(1);
                end
            end
            ST_DRAIN: begin
                ctl_d.pend_vld = 1'b0;
                ctl_d.st       = ST_DONE;
            end
            default: begin
                ctl_d.pend_vld = 1'b0;
                ctl_d.st       = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_en   = (ctl_q.st == ST_ISSUE) && cur_hit;
    assign rd_addr = cur_addr;
    assign done    = (ctl_q.st == ST_DONE);
    assign result  = ctl_q.res;

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result is held while idle and no start arrives
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !start) |=> $stable(result));

    // R2: every read lands inside the table window (modulo wrap, R4)
    p_read_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (HA_W'(rd_addr - HA_W'({ctl_q.base, 1'b0}))
                   < HA_W'(2 * (int'(ctl_q.len) + 1))));

    // R6: lanes advance one per cycle in ascending order
    p_lane_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ISSUE && ctl_q.lane != L_W'(N_LANES - 1))
        |=> (ctl_q.lane == $past(ctl_q.lane) + L_W'(1)));

    // R8: latched operands do not change while busy
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE) |=> ($stable(ctl_q.idx) && $stable(ctl_q.base)
                                   && $stable(ctl_q.len)));
endmodule

// File: tb/tlu_table_lookup_tb.sv
`timescale 1ns/1ps
module tlu_table_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] idx_vec = '0;
    logic [63:0] init_vec = '0;
    logic [4:0]  base_reg = '0;
    logic [1:0]  tbl_len = '0;
    logic        rd_en;
    logic [5:0]  rd_addr;
    logic [63:0] rd_data = '0;
    logic        done;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    logic [63:0] mem [64];
    logic [5:0]  rd_log [16];
    int          rd_cnt = 0;

    always #2.5 clk = ~clk;

    tlu_table_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_vec(idx_vec),
        .init_vec(init_vec), .base_reg(base_reg), .tbl_len(tbl_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .result(result)
    );

    // Vector file model: one-cycle read latency (R9)
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            if (rd_cnt < 16) rd_log[rd_cnt] <= rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(int h, int b);
        return 8'((h * 37 + b * 11 + 5) & 255);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [63:0] iv, logic [63:0] sv, logic [4:0] br,
                          logic [1:0] ln, bit inject);
        logic [63:0] exp_res;
        logic [5:0]  exp_addr [8];
        int          nexp;
        int          lat;
        exp_res = sv;
        nexp = 0;
        for (int k = 0; k < 8; k++) begin
            int i;
            i = int'(iv[k*8 +: 8]);
            if (i < 16 * (int'(ln) + 1)) begin
                int h;
                h = (2 * int'(br) + i / 8) % 64;
                exp_res[k*8 +: 8] = pat(h, i % 8);
                exp_addr[nexp] = 6'(h);
                nexp++;
            end
        end
        @(negedge clk);
        rd_cnt = 0;
        start = 1'b1; idx_vec = iv; init_vec = sv; base_reg = br; tbl_len = ln;
        lat = 0;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 3) begin
                start = 1'b1; idx_vec = ~iv; init_vec = ~sv;
                base_reg = br + 5'd7; tbl_len = ~ln;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        // R7: done in the tenth cycle after the accepting edge
        chk(lat == 10, "R7 latency", 64'(lat), 64'd10);
        // R3 R4 R5 R8: lane contents
        chk(result === exp_res, inject ? "R8 result" : "R3 R4 R5 result",
            result, exp_res);
        // R6: one read per in-range lane
        chk(rd_cnt == nexp, "R6 read count", 64'(rd_cnt), 64'(nexp));
        for (int r = 0; r < nexp && r < rd_cnt; r++) begin
            chk(rd_log[r] == exp_addr[r], "R6 R3 read address order",
                64'(rd_log[r]), 64'(exp_addr[r]));
        end
        @(negedge clk);
        chk(!done, "R7 done pulse", 64'(done), 64'd0);
        chk(result === exp_res, "R7 result hold", result, exp_res);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int h = 0; h < 64; h++)
            for (int b = 0; b < 8; b++)
                mem[h][b*8 +: 8] = pat(h, b);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(rd_en == 1'b0, "R1 rd_en", 64'(rd_en), 64'd0);
        chk(result == 64'd0, "R1 result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 sweep: all indices, all lengths, wrap-prone bases
        for (int ln = 0; ln < 4; ln++) begin
            for (int bi = 0; bi < 4; bi++) begin
                logic [4:0] br;
                br = (bi == 0) ? 5'd0 : (bi == 1) ? 5'd1 : (bi == 2) ? 5'd30 : 5'd31;
                for (int g = 0; g < 32; g++) begin
                    logic [63:0] iv;
                    logic [63:0] sv;
                    for (int k = 0; k < 8; k++)
                        iv[k*8 +: 8] = 8'(g * 8 + ((k * 5) & 7));
                    sv = (g % 2 == 0) ? 64'd0 : {8{8'(g * 13 + ln)}} ^ 64'h0123_4567_89AB_CDEF;
                    run_op(iv, sv, br, 2'(ln), 1'b0);
                end
            end
        end

        // R8: start while busy ignored
        run_op(64'h3F_02_11_47_08_00_1F_39, 64'hDEAD_BEEF_0BAD_F00D, 5'd31, 2'd3, 1'b1);
        run_op(64'hFF_0F_10_05_80_0E_01_40, 64'h0, 5'd3, 2'd0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule